// File: doc/BRIEF.md
# Dual Two-Phase Interval Timer with Watchdog

This peripheral holds two independent down-counting timers behind a small register bus. The bus has a byte address, a write strobe, write data and a combinational read-data return. Each timer runs a repeating period made of two phases, each with its own count register. The timeout phase comes first and keeps the timer's waveform output low. The pulse phase follows and drives the waveform high. A one-cycle interrupt marks the end of every pulse phase, so a full period lasts the timeout count plus the pulse count.

Software programs a timer while it is stopped. It clears the timer's enable bit, writes the two counts and sets the bit again, and the rising enable starts a fresh period from the timeout phase. Timer 0 can also act as a system watchdog. When the low byte of its timeout register holds 0xFF, the upper bits give a watchdog interval. When that interval runs out, a reset request is raised and held.

Top module: `dual_phase_timer`

## Requirements
- R1: After reset every register reads zero, and both waveform outputs, both interrupts and the reset request are low.
- R2: Byte offsets: 0x00 control, 0x04 timer 1 timeout, 0x08 timer 0 timeout, 0x0C timer 1 pulse, 0x10 timer 0 pulse. Each register reads back what was written. Control bits other than bit 0 and bit 1 read zero. Writes to any other address change nothing.
- R3: Control bit 0 enables timer 0 and bit 1 enables timer 1. While its bit is clear, a timer holds its waveform and interrupt low.
- R4: Take the cycles after the clock edge that stores an enable as k = 1, 2, .... An enabled timer with timeout count T and pulse count P drives its waveform low for T cycles and then high for P cycles, and this pattern repeats.
- R5: The interrupt is high for exactly one cycle, the cycle right after each pulse phase ends, that is k = n(T+P)+1 for n ≥ 1.
- R6: A count of zero behaves as a count of one, so the shortest period is two cycles.
- R7: A write to a count register of a timer that is enabled is ignored: the register reads back its old value and the running period is unchanged.
- R8: Counts written while a timer is stopped take effect when it is next enabled, and the new period starts with the timeout phase.
- R9: When bits [7:0] of the timer 0 timeout register equal 0xFF, timer 0 is a watchdog. Bits [31:8] give W (zero behaves as one). The reset request rises in cycle k = W+1, and in this mode timer 0 raises no interrupt and no waveform.
- R10: Once raised, the reset request stays high through disabling and rewriting of the timer, until the block's reset.
- R11: A timer 1 timeout low byte of 0xFF has no special meaning; timer 1 then runs a normal period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| bus_addr | input | 5 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tmr_wave | output | 2 | Waveform per timer, high during the pulse phase |
| tmr_irq | output | 2 | One-cycle interrupt per timer at each period end |
| wdog_rst_req | output | 1 | Sticky watchdog reset request |

## Verification
The bench builds the block with its defaults: 32-bit counters and a 5-bit byte address, which is the full register map. Because the counters can be loaded with values from zero up, the zero-as-one rule, the two-cycle minimum period, unequal and single-cycle phases, and a count whose low byte is 0xFF on timer 1 all run to completion within a few hundred cycles. The watchdog interval sits in the upper 24 bits of the timeout register. Small values such as 0 and 6 therefore make the exact cycle of the reset request observable, along with its stickiness through disabling and its clearing by reset.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
  localparam int NUM_TMR  = 2;
  localparam int OFF_CTRL = 0;
  localparam int WD_LSB   = 8;

  typedef enum logic [1:0] {PH_IDLE, PH_TMO, PH_PLS} phase_e;

  // Timeout count offsets: timer 1 at 0x04, timer 0 at 0x08
  function automatic int tmo_off(input int ch);
    return (ch == 0) ? 8 : 4;
  endfunction

  // Pulse count offsets: timer 1 at 0x0C, timer 0 at 0x10
  function automatic int pls_off(input int ch);
    return (ch == 0) ? 16 : 12;
  endfunction
endpackage

// File: rtl/dpt_regs.sv
module dpt_regs
  import dpt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [ADDR_W-1:0]                addr,
  input  logic                             we,
  input  logic [CNT_W-1:0]                 wdata,
  output logic [CNT_W-1:0]                 rdata,
  output logic [NUM_TMR-1:0]               en,
  output logic [NUM_TMR-1:0][CNT_W-1:0]    tmo,
  output logic [NUM_TMR-1:0][CNT_W-1:0]    pls
);
  logic [NUM_TMR-1:0]            ctrl_q, ctrl_d;
  logic [NUM_TMR-1:0][CNT_W-1:0] tmo_q, tmo_d, pls_q, pls_d;
  logic                          sel_ctrl;
  logic [NUM_TMR-1:0]            sel_tmo, sel_pls;

  assign sel_ctrl = (addr == ADDR_W'(OFF_CTRL));

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_dec
    assign sel_tmo[i] = (addr == ADDR_W'(tmo_off(i)));
    assign sel_pls[i] = (addr == ADDR_W'(pls_off(i)));

    // R7: count registers of a running timer are locked
    p_locked_tmo_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel_tmo[i] && ctrl_q[i]) |=> $stable(tmo_q[i]));
    p_locked_pls_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel_pls[i] && ctrl_q[i]) |=> $stable(pls_q[i]));
  end

  always_comb begin
    ctrl_d = ctrl_q;
    tmo_d  = tmo_q;
    pls_d  = pls_q;
    if (we) begin
      if (sel_ctrl) ctrl_d = wdata[NUM_TMR-1:0];
      for (int i = 0; i < NUM_TMR; i++) begin
        if (sel_tmo[i] && !ctrl_q[i]) tmo_d[i] = wdata;
        if (sel_pls[i] && !ctrl_q[i]) pls_d[i] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tmo_q  <= '0;
      pls_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      tmo_q  <= tmo_d;
      pls_q  <= pls_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_ctrl) rdata = CNT_W'(ctrl_q);
    for (int i = 0; i < NUM_TMR; i++) begin
      if (sel_tmo[i]) rdata = tmo_q[i];
      if (sel_pls[i]) rdata = pls_q[i];
    end
  end

  assign en  = ctrl_q;
  assign tmo = tmo_q;
  assign pls = pls_q;
endmodule

// File: rtl/dpt_channel.sv
module dpt_channel
  import dpt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter bit WDOG_EN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] tmo_val,
  input  logic [CNT_W-1:0] pls_val,
  output logic             wave,
  output logic             irq,
  output logic             wd_req
);
  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en_q, irq_q, irq_d, wd_q, wd_d;
  logic             wd_mode, start, last;
  logic [CNT_W-1:0] wd_raw, tmo_eff, pls_eff;

  function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  if (WDOG_EN) begin : g_wd
    assign wd_mode = (tmo_val[WD_LSB-1:0] == 8'hFF);
    assign wd_raw  = {{WD_LSB{1'b0}}, tmo_val[CNT_W-1:WD_LSB]};
  end else begin : g_nowd
    assign wd_mode = 1'b0;
    assign wd_raw  = '0;
  end

  assign tmo_eff = at_least_one(wd_mode ? wd_raw : tmo_val);
  assign pls_eff = at_least_one(pls_val);
  assign start   = en && !en_q;
  assign last    = (cnt_q == CNT_W'(1));

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    irq_d = 1'b0;
    wd_d  = wd_q;
    if (!en) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
    end else if (start) begin
      ph_d  = PH_TMO;
      cnt_d = tmo_eff;
    end else begin
      unique case (ph_q)
        PH_TMO: begin
          if (!last) cnt_d = cnt_q - 1'b1;
          else if (wd_mode) wd_d = 1'b1;
          else begin
            ph_d  = PH_PLS;
            cnt_d = pls_eff;
          end
        end
        PH_PLS: begin
          if (!last) cnt_d = cnt_q - 1'b1;
          else begin
            ph_d  = PH_TMO;
            cnt_d = tmo_eff;
            irq_d = 1'b1;
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      en_q  <= 1'b0;
      irq_q <= 1'b0;
      wd_q  <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      en_q  <= en;
      irq_q <= irq_d;
      wd_q  <= wd_d;
    end
  end

  assign wave   = (ph_q == PH_PLS);
  assign irq    = irq_q;
  assign wd_req = wd_q;

  p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_irq_at_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $fell(wave));
  p_quiet_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!wave && !irq));
  p_cnt_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE) |-> (cnt_q != '0));
  p_wd_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wd_req |=> wd_req);
  p_wd_no_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_mode |-> (!irq && !wave));
endmodule

// File: rtl/dual_phase_timer.sv
module dual_phase_timer
  import dpt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [CNT_W-1:0]   bus_wdata,
  output logic [CNT_W-1:0]   bus_rdata,
  output logic [NUM_TMR-1:0] tmr_wave,
  output logic [NUM_TMR-1:0] tmr_irq,
  output logic               wdog_rst_req
);
  logic [1:0]                    rs_q;
  logic                          srst_n;
  logic [NUM_TMR-1:0]            en;
  logic [NUM_TMR-1:0][CNT_W-1:0] tmo, pls;
  logic [NUM_TMR-1:0]            wd_vec;

  // Reset asserts at once and leaves two edges after rst_n rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  dpt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst_n (srst_n),
    .addr  (bus_addr),
    .we    (bus_we),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .en    (en),
    .tmo   (tmo),
    .pls   (pls)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_ch
    dpt_channel #(.CNT_W(CNT_W), .WDOG_EN(i == 0)) u_ch (
      .clk     (clk),
      .rst_n   (srst_n),
      .en      (en[i]),
      .tmo_val (tmo[i]),
      .pls_val (pls[i]),
      .wave    (tmr_wave[i]),
      .irq     (tmr_irq[i]),
      .wd_req  (wd_vec[i])
    );
  end

  assign wdog_rst_req = |wd_vec;

  p_rst_req_hold_r10: assert property (@(posedge clk) disable iff (!srst_n)
    wdog_rst_req |=> wdog_rst_req);
endmodule

// File: tb/tb_dual_phase_timer.sv
module tb_dual_phase_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  tmr_wave, tmr_irq;
  logic        wdog_rst_req;
  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_phase_timer dut (.*);

  // Vector table: {timer, timeout, pulse}
  localparam int NV = 6;
  localparam int VCH [NV] = '{0, 1, 0, 1, 0, 1};
  localparam int VT  [NV] = '{3, 1, 0, 5, 2, 255};
  localparam int VP  [NV] = '{2, 1, 0, 1, 4, 3};

  task automatic chk(input bit ok, input string rid, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rid, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [4:0] tmo_a(input int ch);
    return (ch == 0) ? 5'h08 : 5'h04;
  endfunction
  function automatic logic [4:0] pls_a(input int ch);
    return (ch == 0) ? 5'h10 : 5'h0C;
  endfunction

  // Sample cycles k0..kn after the enable edge; caller sits at negedge of k0-1
  task automatic run_check(input int ch, input int t, input int p, input int k0,
                           input int kn, input string rid);
    int te, pe, m;
    bit ok;
    logic [31:0] act, exp;
    te = (t == 0) ? 1 : t;
    pe = (p == 0) ? 1 : p;
    ok = 1'b1; act = '0; exp = '0;
    for (int k = k0; k <= kn; k++) begin
      logic ew, ei;
      @(negedge clk);
      m  = (k - 1) % (te + pe);
      ew = (m >= te);
      ei = (k > te + pe) && (m == 0);
      if (ok && (tmr_wave[ch] !== ew || tmr_irq[ch] !== ei ||
                 tmr_wave[1-ch] !== 1'b0 || tmr_irq[1-ch] !== 1'b0)) begin
        ok  = 1'b0;
        act = {k[15:0], 4'h0, tmr_wave, tmr_irq, 4'h0};
        exp = {k[15:0], 4'h0, (ch == 1) ? {ew, 1'b0, ei, 1'b0} : {1'b0, ew, 1'b0, ei}, 4'h0};
      end
    end
    chk(ok, rid, act, exp);
  endtask

  task automatic start_timer(input int ch, input logic [31:0] t, input logic [31:0] p);
    bus_wr(5'h00, 32'h0);
    bus_wr(tmo_a(ch), t);
    bus_wr(pls_a(ch), p);
    bus_wr(5'h00, 32'(1 << ch));
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    do_reset();

    // R1: reset state
    for (int a = 0; a <= 16; a += 4) begin
      bus_rd(5'(a), rd);
      chk(rd == 0, "R1 reset read", rd, 0);
    end
    chk(tmr_wave == 0 && tmr_irq == 0 && !wdog_rst_req, "R1 outputs",
        {27'b0, wdog_rst_req, tmr_wave, tmr_irq}, 0);

    // R2: offsets and readback
    bus_wr(5'h04, 32'h1111_0004); bus_wr(5'h08, 32'h2222_0008);
    bus_wr(5'h0C, 32'h3333_000C); bus_wr(5'h10, 32'h4444_0010);
    bus_wr(5'h14, 32'hDEAD_BEEF);
    bus_rd(5'h04, rd); chk(rd == 32'h1111_0004, "R2 t1 timeout", rd, 32'h1111_0004);
    bus_rd(5'h08, rd); chk(rd == 32'h2222_0008, "R2 t0 timeout", rd, 32'h2222_0008);
    bus_rd(5'h0C, rd); chk(rd == 32'h3333_000C, "R2 t1 pulse", rd, 32'h3333_000C);
    bus_rd(5'h10, rd); chk(rd == 32'h4444_0010, "R2 t0 pulse", rd, 32'h4444_0010);
    bus_rd(5'h14, rd); chk(rd == 0, "R2 unmapped", rd, 0);
    bus_wr(5'h00, 32'hFFFF_FFFC);
    bus_rd(5'h00, rd); chk(rd == 0, "R2 unused ctrl bits", rd, 0);

    // R4 R5 R6 R11 R3: vector table, other timer stays quiet
    for (int v = 0; v < NV; v++) begin
      int te, pe;
      te = (VT[v] == 0) ? 1 : VT[v];
      pe = (VP[v] == 0) ? 1 : VP[v];
      start_timer(VCH[v], VT[v], VP[v]);
      run_check(VCH[v], VT[v], VP[v], 1, 3 * (te + pe) + 2,
                (VT[v] == 255) ? "R11 ff code on timer 1" :
                (VT[v] == 0)   ? "R6 zero counts" : "R4 R5 period");
    end

    // R7: write while running is ignored
    start_timer(1, 4, 3);
    bus_wr(5'h04, 32'd9);
    run_check(1, 4, 3, 3, 30, "R7 running period unchanged");
    bus_rd(5'h04, rd); chk(rd == 4, "R7 readback unchanged", rd, 4);

    // R8: new values after stop and restart
    start_timer(1, 2, 2);
    run_check(1, 2, 2, 1, 14, "R8 restart with new counts");

    // R3: disabling stops the timer
    bus_wr(5'h00, 32'h0);
    begin
      bit quiet = 1'b1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (tmr_wave != 0 || tmr_irq != 0) quiet = 1'b0;
      end
      chk(quiet, "R3 disabled quiet", {30'b0, tmr_wave}, 0);
    end

    // R9: watchdog W=6
    start_timer(0, (32'd6 << 8) | 32'hFF, 32'd2);
    begin
      bit ok = 1'b1;
      for (int k = 1; k <= 12; k++) begin
        @(negedge clk);
        if (wdog_rst_req !== (k >= 7) || tmr_irq[0] || tmr_wave[0]) ok = 1'b0;
        if (k == 6) chk(!wdog_rst_req, "R9 not yet at W", wdog_rst_req, 0);
        if (k == 7) chk(wdog_rst_req, "R9 request at W+1", wdog_rst_req, 1);
      end
      chk(ok, "R9 no irq or wave in watchdog", {30'b0, tmr_wave[0], tmr_irq[0]}, 0);
    end

    // R10: sticky through disable and rewrite
    bus_wr(5'h00, 32'h0);
    bus_wr(5'h08, 32'd5);
    repeat (10) @(negedge clk);
    chk(wdog_rst_req, "R10 sticky", wdog_rst_req, 1);
    do_reset();
    chk(!wdog_rst_req, "R10 cleared by reset", wdog_rst_req, 0);

    // R9: zero interval behaves as one
    start_timer(0, 32'h0000_00FF, 32'd0);
    @(negedge clk);
    chk(!wdog_rst_req, "R9 zero interval k1", wdog_rst_req, 0);
    @(negedge clk);
    chk(wdog_rst_req, "R9 zero interval k2", wdog_rst_req, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule